// File: doc/BRIEF.md
# Journal Row SEC-DED Codec

This block protects one row of a write journal with a systematic single-error-correcting, double-error-detecting code. A row holds 34 information bits: a 16-bit address, a 16-bit data word, a "written" flag and a "validated" flag. The encoder adds 7 check bits to make a 41-bit codeword. The decoder takes a 41-bit codeword that was stored earlier. It regenerates the check bits from the stored information bits and XORs them with the stored check bits to form a syndrome. From the syndrome it corrects a single flipped bit, or it reports that the word cannot be corrected.

Each column of the parity-check matrix has odd weight. The information columns are weight-3 vectors and the check columns are unit vectors. Because of this, the parity of the syndrome's weight separates single errors from double errors without extra logic. The encoder is purely combinational. A parameter can place a register stage on the decoder outputs to help timing.

Top module: `hs_row_codec`

## Requirements
- R1: Information bit i uses as its column the i-th 7-bit value of Hamming weight three, counted in ascending numeric order, for i = 0..33. Check bit j is the XOR of every information bit whose column has bit j set.
- R2: Information field layout is data in bits 15:0, address in bits 31:16, written flag in bit 32 and validated flag in bit 33. The codeword carries the information field in bits 33:0 and check bit j in bit 34+j.
- R3: Check rows 0..3 each cover 15 information bits and rows 4..6 each cover 14, so an all-ones information field encodes to check value 7'b0001111.
- R4: A zero syndrome raises neither flag, and the decoded information equals the received bits 33:0.
- R5: A single flipped bit at any codeword position 0..40 raises the correction flag and not the uncorrectable flag. The position output then gives that bit index, and the decoded information equals the original information.
- R6: Any two flipped bits give a nonzero even-weight syndrome, which raises the uncorrectable flag and not the correction flag.
- R7: An odd-weight syndrome that matches no column (for example 7'b1110000, the unused weight-3 value) raises the uncorrectable flag and not the correction flag.
- R8: When the correction flag is low, the position output is 0 and the decoded information equals the received bits 33:0.
- R9: With REG_OUT=1 (the default), the decoder outputs appear one clock after the codeword is presented, and they are all zero while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional decoder output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| enc_addr | input | 16 | Address field to encode |
| enc_data | input | 16 | Data field to encode |
| enc_wr | input | 1 | Written flag to encode |
| enc_val | input | 1 | Validated flag to encode |
| enc_chk | output | 7 | Check bits for the encoder inputs |
| dec_word | input | 41 | Stored codeword to check |
| dec_info | output | 34 | Corrected information field |
| dec_fix | output | 1 | A single error was corrected |
| dec_unc | output | 1 | The error cannot be corrected |
| dec_pos | output | 6 | Index of the corrected bit, 0 when none |

## Verification
A wrong column assignment or a broken XOR row first shows at enc_chk, in the same cycle the information changes. It also shows at the decoder one cycle later, as spurious flags on clean words. A fault in the syndrome match logic shows as the wrong dec_pos, as a corrected bit flipped back into dec_info, or as the two flags disagreeing with the syndrome weight. Every one of these appears on the first decode after the faulty codeword is presented. Single and double errors are injected at random positions on top of directed cases: all-ones information, each check bit, and the unused weight-3 syndrome.

// File: rtl/hs_pkg.sv
package hs_pkg;
  parameter int HS_ADDR_W = 16;
  parameter int HS_DATA_W = 16;
  parameter int HS_INFO_W = HS_ADDR_W + HS_DATA_W + 2;
  parameter int HS_CHK_W  = 7;
  parameter int HS_CW_W   = HS_INFO_W + HS_CHK_W;
  parameter int HS_POS_W  = $clog2(HS_CW_W);

  function automatic int hs_pop(input logic [HS_CHK_W-1:0] v);
    int n;
    n = 0;
    for (int b = 0; b < HS_CHK_W; b++) n += int'(v[b]);
    return n;
  endfunction

  // idx-th weight-3 value in ascending numeric order
  function automatic logic [HS_CHK_W-1:0] hs_info_col(input int idx);
    int seen;
    logic [HS_CHK_W-1:0] res;
    seen = 0;
    res  = '0;
    for (int v = 0; v < (1 << HS_CHK_W); v++) begin
      if (hs_pop(HS_CHK_W'(v)) == 3) begin
        if (seen == idx) res = HS_CHK_W'(v);
        seen++;
      end
    end
    return res;
  endfunction

  // parity-check column of codeword position p
  function automatic logic [HS_CHK_W-1:0] hs_col(input int p);
    if (p < HS_INFO_W) return hs_info_col(p);
    return HS_CHK_W'(1) << (p - HS_INFO_W);
  endfunction

  // information bits covered by check row j
  function automatic logic [HS_INFO_W-1:0] hs_row_mask(input int j);
    logic [HS_INFO_W-1:0] m;
    logic [HS_CHK_W-1:0] c;
    m = '0;
    for (int i = 0; i < HS_INFO_W; i++) begin
      c = hs_info_col(i);
      m[i] = c[j];
    end
    return m;
  endfunction
endpackage

// File: rtl/hs_enc.sv
module hs_enc
  import hs_pkg::*;
#(
  parameter int INFO_W = HS_INFO_W,
  parameter int CHK_W  = HS_CHK_W
) (
  input  logic [INFO_W-1:0] info,
  output logic [CHK_W-1:0]  chk
);
  for (genvar j = 0; j < CHK_W; j++) begin : g_row
    localparam logic [INFO_W-1:0] ROW_MASK = hs_row_mask(j);
    assign chk[j] = ^(info & ROW_MASK);
  end
endmodule

// File: rtl/hs_dec.sv
module hs_dec
  import hs_pkg::*;
#(
  parameter int INFO_W = HS_INFO_W,
  parameter int CHK_W  = HS_CHK_W,
  parameter int CW_W   = INFO_W + CHK_W,
  parameter int POS_W  = $clog2(CW_W)
) (
  input  logic [CW_W-1:0]   word,
  output logic [CHK_W-1:0]  syn,
  output logic [INFO_W-1:0] info,
  output logic              fix,
  output logic              unc,
  output logic [POS_W-1:0]  pos
);
  logic [CHK_W-1:0] regen;
  logic [CW_W-1:0]  hit;
  logic [CW_W-1:0]  fixed_word;

  hs_enc #(.INFO_W(INFO_W), .CHK_W(CHK_W)) regen_i (
    .info (word[INFO_W-1:0]),
    .chk  (regen)
  );

  assign syn = regen ^ word[CW_W-1:INFO_W];

  for (genvar p = 0; p < CW_W; p++) begin : g_match
    localparam logic [CHK_W-1:0] COL = hs_col(p);
    assign hit[p] = (syn == COL);
  end

  always_comb begin
    pos = '0;
    for (int p = 0; p < CW_W; p++)
      if (hit[p]) pos = POS_W'(p);
  end

  assign fix        = |hit;
  assign unc        = (syn != '0) && !fix;
  assign fixed_word = word ^ hit;
  assign info       = fixed_word[INFO_W-1:0];
endmodule

// File: rtl/hs_row_codec.sv
module hs_row_codec
  import hs_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [HS_ADDR_W-1:0] enc_addr,
  input  logic [HS_DATA_W-1:0] enc_data,
  input  logic                 enc_wr,
  input  logic                 enc_val,
  output logic [HS_CHK_W-1:0]  enc_chk,
  input  logic [HS_CW_W-1:0]   dec_word,
  output logic [HS_INFO_W-1:0] dec_info,
  output logic                 dec_fix,
  output logic                 dec_unc,
  output logic [HS_POS_W-1:0]  dec_pos
);
  logic [HS_INFO_W-1:0] enc_info;
  logic [HS_CHK_W-1:0]  dec_syn;
  logic [HS_INFO_W-1:0] c_info;
  logic                 c_fix;
  logic                 c_unc;
  logic [HS_POS_W-1:0]  c_pos;

  assign enc_info = {enc_val, enc_wr, enc_addr, enc_data};

  hs_enc enc_i (.info(enc_info), .chk(enc_chk));

  hs_dec dec_i (
    .word (dec_word),
    .syn  (dec_syn),
    .info (c_info),
    .fix  (c_fix),
    .unc  (c_unc),
    .pos  (c_pos)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dec_info <= '0;
        dec_fix  <= 1'b0;
        dec_unc  <= 1'b0;
        dec_pos  <= '0;
      end else begin
        dec_info <= c_info;
        dec_fix  <= c_fix;
        dec_unc  <= c_unc;
        dec_pos  <= c_pos;
      end
    end
  end else begin : g_comb
    assign dec_info = c_info;
    assign dec_fix  = c_fix;
    assign dec_unc  = c_unc;
    assign dec_pos  = c_pos;
  end
endmodule

module hs_row_codec_chk
  import hs_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [HS_CW_W-1:0]   dec_word,
  input logic [HS_CHK_W-1:0]  dec_syn,
  input logic [HS_INFO_W-1:0] dec_info,
  input logic                 dec_fix,
  input logic                 dec_unc,
  input logic [HS_POS_W-1:0]  dec_pos
);
  logic [HS_CW_W-1:0]  a_word;
  logic [HS_CHK_W-1:0] a_syn;

  if (REG_OUT) begin : g_align
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        a_word <= '0;
        a_syn  <= '0;
      end else begin
        a_word <= dec_word;
        a_syn  <= dec_syn;
      end
    end
  end else begin : g_pass
    assign a_word = dec_word;
    assign a_syn  = dec_syn;
  end

  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_syn == '0) |-> (!dec_fix && !dec_unc && dec_info == a_word[HS_INFO_W-1:0])); // R4
  AST_EVEN_UNC: assert property (@(posedge clk) disable iff (!rst_n)
    (a_syn != '0 && !($countones(a_syn) % 2)) |-> (dec_unc && !dec_fix)); // R6
  AST_FIX_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fix |-> ($countones(a_syn) % 2 == 1 && dec_pos < HS_POS_W'(HS_CW_W))); // R5
  AST_FIX_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fix |-> ($countones(dec_info ^ a_word[HS_INFO_W-1:0]) <= 1)); // R5
  AST_NOFIX_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_fix |-> (dec_pos == '0 && dec_info == a_word[HS_INFO_W-1:0])); // R8
  AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec_fix, dec_unc})); // R7
endmodule

bind hs_row_codec hs_row_codec_chk #(.REG_OUT(REG_OUT)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .dec_word (dec_word),
  .dec_syn  (dec_syn),
  .dec_info (dec_info),
  .dec_fix  (dec_fix),
  .dec_unc  (dec_unc),
  .dec_pos  (dec_pos)
);

// File: tb/hs_row_codec_tb.sv
module hs_row_codec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] enc_addr = '0;
  logic [15:0] enc_data = '0;
  logic        enc_wr = 1'b0;
  logic        enc_val = 1'b0;
  logic [6:0]  enc_chk;
  logic [40:0] dec_word = '0;
  logic [33:0] dec_info;
  logic        dec_fix;
  logic        dec_unc;
  logic [5:0]  dec_pos;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hs_row_codec dut_i (.*);

  // ascending weight-3 values: top bit c, then b, then a
  function automatic logic [6:0] t_col(input int idx);
    int k;
    logic [6:0] r;
    k = 0;
    r = '0;
    for (int c = 2; c < 7; c++)
      for (int b = 1; b < c; b++)
        for (int a = 0; a < b; a++) begin
          if (k == idx) r = 7'((1 << a) | (1 << b) | (1 << c));
          k++;
        end
    return r;
  endfunction

  function automatic logic [6:0] t_enc(input logic [33:0] inf);
    logic [6:0] s;
    s = '0;
    for (int i = 0; i < 34; i++) if (inf[i]) s ^= t_col(i);
    return s;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_info(input logic [33:0] inf);
    {enc_val, enc_wr, enc_addr, enc_data} = inf;
  endtask

  // present word, check decoder one cycle later
  task automatic decode(input logic [40:0] w, input logic [33:0] e_info,
                        input bit e_fix, input bit e_unc, input int e_pos, input string req);
    @(negedge clk);
    dec_word = w;
    @(negedge clk);
    chk({req, " info"}, 64'(dec_info), 64'(e_info));
    chk({req, " fix"},  64'(dec_fix),  64'(e_fix));
    chk({req, " unc"},  64'(dec_unc),  64'(e_unc));
    chk({req, " pos"},  64'(dec_pos),  64'(e_pos));
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [33:0] inf;
    logic [40:0] cw;
    void'($urandom(32'hC0DE5EED));
    dec_word = {7'h55, 34'h3_0000_FFFF};
    repeat (3) @(negedge clk);
    // R9: reset clears decoder outputs
    chk("R9 reset info", 64'(dec_info), 64'h0);
    chk("R9 reset flags", 64'({dec_fix, dec_unc, dec_pos}), 64'h0);
    rst_n = 1'b1;

    // R3: all-ones information
    @(negedge clk);
    drive_info('1);
    #1 chk("R3 all-ones chk", 64'(enc_chk), 64'h0F);
    // R1/R2: single information bits map to their columns
    for (int i = 0; i < 34; i += 11) begin
      drive_info(34'(1) << i);
      #1 chk("R1 column chk", 64'(enc_chk), 64'(t_col(i)));
    end
    drive_info({1'b1, 1'b0, 16'h0000, 16'h0000});
    #1 chk("R2 vflag bit33", 64'(enc_chk), 64'(t_col(33)));

    // R9: latency, output still shows previous value right after drive
    inf = 34'h2_1234_ABCD;
    cw = {t_enc(inf), inf};
    decode(cw, inf, 1'b0, 1'b0, 0, "R4 clean");
    @(negedge clk);
    dec_word = cw ^ (41'(1) << 3);
    #1 chk("R9 latency hold", 64'({dec_fix, dec_info}), 64'({1'b0, inf}));
    @(negedge clk);
    chk("R9 latency fix", 64'({dec_fix, dec_pos}), 64'({1'b1, 6'd3}));

    // R7: unused weight-3 syndrome
    decode({7'b1110000, 34'h0}, 34'h0, 1'b0, 1'b1, 0, "R7 unmatched odd");
    // R5: every check-bit position
    for (int p = 34; p < 41; p++)
      decode(41'(1) << p, 34'h0, 1'b1, 1'b0, p, "R5 check pos");
    // R6: two check bits
    decode({7'b0000011, 34'h0}, 34'h0, 1'b0, 1'b1, 0, "R6 two check");

    // random mixes
    for (int n = 0; n < 300; n++) begin
      int k;
      int p1;
      int p2;
      logic [40:0] w;
      inf = {2'($urandom), $urandom};
      @(negedge clk);
      drive_info(inf);
      #1 chk("R1 random enc", 64'(enc_chk), 64'(t_enc(inf)));
      cw = {t_enc(inf), inf};
      k  = int'($urandom % 3);
      p1 = int'($urandom % 41);
      p2 = (p1 + 1 + int'($urandom % 40)) % 41;
      if (k == 0) decode(cw, inf, 1'b0, 1'b0, 0, "R4 random clean");
      else if (k == 1) decode(cw ^ (41'(1) << p1), inf, 1'b1, 1'b0, p1, "R5 random single");
      else begin
        w = cw ^ (41'(1) << p1) ^ (41'(1) << p2);
        decode(w, w[33:0], 1'b0, 1'b1, 0, "R6 R8 random double");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule